// File: doc/BRIEF.md
# Reset Cause Capture Register

This block records which kind of reset last hit the device. Four reset sources feed it: power-on, the external reset pin, the brown-out detector and the watchdog. Each arrives as a synchronous pulse one clock wide. Each source owns a sticky flag in an 8-bit status byte, and the byte is always visible on the output. A single-register write port lets software clear flags. Software clears a flag by writing zero to it. Writing one to a flag leaves it alone.

The flags live in state that no ordinary reset touches. Only the power-on pulse forces a known value: it sets the power-on flag and clears the other three in the same update. This gives a simple routine at start-up. Software reads the byte, clears it with a zero write, and the next reset leaves exactly one flag behind that names its cause. Every update lands on the clock edge where the pulse or the write is sampled, and `status_o` shows it from that edge on.

Top module: `rst_cause_status`

## Requirements
- R1: Bits 7 to 4 of `status_o` always read zero. A write carrying ones in those bits changes nothing there.
- R2: A power-on pulse sets bit 0 (power-on flag). `status_o` shows it after the sampling edge. After the first power-on pulse with no other activity, the byte reads 0x01.
- R3: A power-on pulse clears bits 3 to 1 in the same update. This holds even when any of their own set pulses arrive in the same cycle.
- R4: A watchdog pulse sets bit 3, a brown-out pulse sets bit 2 and an external-pin pulse sets bit 1. Each flag is visible one edge after its pulse, and several may set together.
- R5: A write with `wr_en_i` high clears every flag among bits 3 to 0 whose data bit is 0. Flags whose data bit is 1 keep their value.
- R6: When a set pulse for bits 3 to 1 meets a zero write to the same bit in one cycle, the flag ends set.
- R7: Without a pulse or a write, every flag holds its value. Flags stay set across watchdog, brown-out and external resets.
- R8: Bit 0 is cleared only by a zero write. If a power-on pulse and a zero write to bit 0 come in the same cycle, bit 0 ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_evt_i | input | 1 | One-cycle power-on reset pulse |
| ext_evt_i | input | 1 | One-cycle external pin reset pulse |
| bod_evt_i | input | 1 | One-cycle brown-out reset pulse |
| wdt_evt_i | input | 1 | One-cycle watchdog reset pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data; a 0 in bits 3..0 clears that flag |
| status_o | output | 8 | Reset cause status byte |

## Verification
On every cycle after the first power-on pulse, the assertions check the update rules of each flag cell. These are the dominance of power-on, the win of a set over a clear, a zero write clearing, and holding when idle. They also check that reserved bits stay zero after writes touch them. Only the bench scenarios show that each pulse reaches the right bit position. Only they show the priority holding across all combinations of pulse pattern, write data and starting byte, and the plain read-back value after start-up. The bench reaches those combinations by sweeping every starting byte against every pulse set and write nibble.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  localparam int STAT_W  = 8;
  localparam int NUM_SRC = 4;

  localparam int POS_POR = 0;
  localparam int POS_EXT = 1;
  localparam int POS_BOD = 2;
  localparam int POS_WDT = 3;

  // Priority of one flag update: forced clear, then set, then software clear, then hold.
  function automatic logic flag_next(input logic cur,
                                     input logic set,
                                     input logic force_clr,
                                     input logic sw_clr);
    logic nxt;
    if (force_clr)   nxt = 1'b0;
    else if (set)    nxt = 1'b1;
    else if (sw_clr) nxt = 1'b0;
    else             nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/rst_cause_wr_decode.sv
module rst_cause_wr_decode #(
  parameter int STAT_W  = 8,
  parameter int NUM_SRC = 4
) (
  input  logic               wr_en_i,
  input  logic [STAT_W-1:0]  wr_data_i,
  output logic [NUM_SRC-1:0] clr_o,
  output logic               rsvd_touch_o
);

  localparam int RSVD_W = STAT_W - NUM_SRC;

  // A zero in a flag position of the write data requests a clear.
  always_comb begin
    clr_o = '0;
    if (wr_en_i) clr_o = ~wr_data_i[NUM_SRC-1:0];
  end

  // Ones written toward reserved bits: brought out only for checking.
  generate
    if (RSVD_W > 0) begin : g_rsvd
      assign rsvd_touch_o = wr_en_i & (|wr_data_i[STAT_W-1:NUM_SRC]);
    end else begin : g_no_rsvd
      assign rsvd_touch_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/rst_cause_flag.sv
module rst_cause_flag
  import rst_cause_pkg::*;
(
  input  logic clk_i,
  input  logic arm_i,
  input  logic set_i,
  input  logic force_clr_i,
  input  logic sw_clr_i,
  output logic q_o
);

  logic q_q;

  // State with no reset: only the power-on path gives it a known value.
  always_ff @(posedge clk_i) begin
    q_q <= flag_next(q_q, set_i, force_clr_i, sw_clr_i);
  end

  assign q_o = q_q;

  AST_FORCE_CLEARS: assert property (@(posedge clk_i) disable iff (!arm_i)
    force_clr_i |=> !q_o);                                             // R3
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!arm_i)
    (set_i && !force_clr_i) |=> q_o);                                  // R6
  AST_ZERO_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!arm_i)
    (sw_clr_i && !set_i && !force_clr_i) |=> !q_o);                    // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!arm_i)
    (!sw_clr_i && !set_i && !force_clr_i) |=> $stable(q_o));           // R7

endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
  import rst_cause_pkg::*;
(
  input  logic              clk_i,
  input  logic              por_evt_i,
  input  logic              ext_evt_i,
  input  logic              bod_evt_i,
  input  logic              wdt_evt_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] status_o
);

  localparam int RSVD_W = STAT_W - NUM_SRC;

  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] sw_clr;
  logic [NUM_SRC-1:0] flag_q;
  logic               rsvd_touch;
  logic               por_seen_q;

  always_comb begin
    evt_vec          = '0;
    evt_vec[POS_POR] = por_evt_i;
    evt_vec[POS_EXT] = ext_evt_i;
    evt_vec[POS_BOD] = bod_evt_i;
    evt_vec[POS_WDT] = wdt_evt_i;
  end

  // Arms the checks once the state has been forced to a known value.
  always_ff @(posedge clk_i) begin
    por_seen_q <= por_seen_q | por_evt_i;
  end

  rst_cause_wr_decode #(
    .STAT_W  (STAT_W),
    .NUM_SRC (NUM_SRC)
  ) i_wr_decode (
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .clr_o        (sw_clr),
    .rsvd_touch_o (rsvd_touch)
  );

  generate
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_flag
      if (gi == POS_POR) begin : g_por
        rst_cause_flag i_flag (
          .clk_i       (clk_i),
          .arm_i       (por_seen_q),
          .set_i       (evt_vec[gi]),
          .force_clr_i (1'b0),
          .sw_clr_i    (sw_clr[gi]),
          .q_o         (flag_q[gi])
        );
      end else begin : g_src
        rst_cause_flag i_flag (
          .clk_i       (clk_i),
          .arm_i       (por_seen_q),
          .set_i       (evt_vec[gi]),
          .force_clr_i (por_evt_i),
          .sw_clr_i    (sw_clr[gi]),
          .q_o         (flag_q[gi])
        );
      end
    end
  endgenerate

  assign status_o = {{RSVD_W{1'b0}}, flag_q};

  AST_RSVD_STAY_ZERO: assert property (@(posedge clk_i) disable iff (!por_seen_q)
    rsvd_touch |=> (status_o[STAT_W-1:NUM_SRC] == '0));                // R1
  AST_POR_FLAG_SETS: assert property (@(posedge clk_i) disable iff (!por_seen_q)
    por_evt_i |=> status_o[POS_POR]);                                  // R8
  AST_POR_CLEARS_OTHERS: assert property (@(posedge clk_i) disable iff (!por_seen_q)
    por_evt_i |=> (status_o[NUM_SRC-1:1] == '0));                      // R3

endmodule

// File: tb/test_rst_cause_status.sv
`timescale 1ns/1ps
module test_rst_cause_status;

  logic       clk = 1'b0;
  logic       por = 1'b0, ext = 1'b0, bod = 1'b0, wdt = 1'b0, we = 1'b0;
  logic [7:0] wd  = 8'h00;
  logic [7:0] stat;
  logic [3:0] model = 4'h0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rst_cause_status i_rst_cause_status (
    .clk_i     (clk),
    .por_evt_i (por),
    .ext_evt_i (ext),
    .bod_evt_i (bod),
    .wdt_evt_i (wdt),
    .wr_en_i   (we),
    .wr_data_i (wd),
    .status_o  (stat)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge and update the bench model arithmetically.
  task automatic step(input logic p, input logic [3:1] ev, input logic w, input logic [7:0] d);
    logic [3:0] clrmask;
    @(negedge clk);
    por = p; ext = ev[1]; bod = ev[2]; wdt = ev[3]; we = w; wd = d;
    @(posedge clk);
    #1;
    clrmask = w ? ~d[3:0] : 4'h0;
    model   = p ? 4'b0001 : ((model & ~clrmask) | {ev, 1'b0});
    por = 1'b0; ext = 1'b0; bod = 1'b0; wdt = 1'b0; we = 1'b0; wd = 8'h00;
  endtask

  task automatic load(input logic [3:0] s);
    step(1'b1, 3'b000, 1'b0, 8'h00);
    step(1'b0, s[3:1], !s[0], 8'hFE);
  endtask

  initial begin
    // R2: start-up value after the first power-on pulse
    step(1'b1, 3'b000, 1'b0, 8'h00);
    check("R2 first power-on", stat, 8'h01);
    step(1'b0, 3'b000, 1'b0, 8'h00);
    check("R7 idle hold", stat, 8'h01);
    // R4: each source lands in its own bit
    step(1'b0, 3'b100, 1'b0, 8'h00);
    check("R4 watchdog bit3", stat, 8'h09);
    step(1'b0, 3'b010, 1'b0, 8'h00);
    check("R4 brown-out bit2", stat, 8'h0D);
    step(1'b0, 3'b001, 1'b0, 8'h00);
    check("R4 external bit1", stat, 8'h0F);
    // R5: ones leave flags, zero clears
    step(1'b0, 3'b000, 1'b1, 8'hFF);
    check("R5 write ones keeps", stat, 8'h0F);
    step(1'b0, 3'b000, 1'b1, 8'hF5);
    check("R5 write zeros clears", stat, 8'h05);
    // R1: reserved bits never set
    step(1'b0, 3'b000, 1'b1, 8'hF0);
    check("R1 reserved after write", stat, 8'h00);
    // R6: set beats zero write
    step(1'b0, 3'b100, 1'b1, 8'h00);
    check("R6 set wins", stat, 8'h08);
    // R8: power-on beats zero write to bit0
    step(1'b1, 3'b111, 1'b1, 8'h00);
    check("R8 por beats clear", stat, 8'h01);
    check("R3 por clears others", stat & 8'h0E, 8'h00);
    step(1'b0, 3'b010, 1'b0, 8'h00);
    check("R7 non-por reset keeps por flag", stat, 8'h05);
    step(1'b0, 3'b000, 1'b1, 8'hFE);
    check("R8 software clears por flag", stat, 8'h04);

    // Sweep: every start byte, pulse set and write nibble
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        for (int w = 0; w < 2; w++) begin
          for (int n = 0; n < 16; n++) begin
            logic [7:0] d;
            string tag;
            d = {~n[3:0], n[3:0]};
            load(s[3:0]);
            step(e[0], e[3:1], w[0], d);
            if (stat[7:4] != 4'h0)                                 tag = "R1 sweep";
            else if (e[0])                                         tag = "R3 sweep";
            else if (w[0] && ((e[3:1] & ~n[3:1]) != 3'b000))       tag = "R6 sweep";
            else if (w[0])                                         tag = "R5 sweep";
            else if (e[3:1] != 3'b000)                             tag = "R4 sweep";
            else                                                   tag = "R7 sweep";
            check(tag, stat, {4'h0, model});
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R7 actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule